// File: doc/BRIEF.md
# Three-Wire Control Bus Slave

This block is the device end of a three-wire microcontroller control bus made of a bus clock, a data line and a mode line. The host selects the device in an address phase, which it marks by holding the mode line low. It then moves one or more bytes in a data phase, which it marks by holding the mode line high. The block matches a fixed 6-bit device identifier and decodes a 2-bit transfer code carried in the same byte.

For a write, the block takes a register-address byte and a 16-bit value, then performs one write on a simple register-file port. For a read, the host first arms a register in a separate prepare step. In a later read phase the block sends back the register address byte, whose lowest bit flags whether the address is valid, followed by the register contents. All bus inputs are asynchronous to the block clock and pass through a synchroniser. Bus edges are then found as events in the block clock domain.

Top module: `tw_ctl_slave`

## Requirements
- R1: Every byte on the data line travels least significant bit first. The block samples an incoming bit on each rising edge of the bus clock.
- R2: An address phase is a period with the mode line low that carries 8 bus clock pulses. In the byte received, bits 7..2 are compared with the device identifier 6'b010100 and bits 1..0 form the transfer code.
- R3: Transfer code 2'b10 selects the device for write or prepare. The first byte of the following data phase carries direction in bit 0 (0 = write, 1 = prepare read) and the 7-bit register address in bits 7..1.
- R4: After a write address byte, the next two data-phase bytes form the value, most significant byte first. On the second byte `reg_we` pulses for one clock with `reg_addr` and `reg_wdata` holding the address and value. Any further bytes in that data phase cause no write.
- R5: An identifier mismatch, or transfer code 2'b00 or 2'b01, makes the block ignore the data phase that follows. It produces no write and does not drive the data line until a new address phase begins.
- R6: Transfer code 2'b11 starts a read. During the next data phase the block returns 24 bits: the register address byte (address in bits 7..1, flag in bit 0), then the most significant data byte, then the least significant data byte. Each byte goes out least significant bit first.
- R7: The flag bit is 0 only when a prepare read armed the register and `reg_addr_ok` is high for it. A write clears the arming, so a read without a new prepare returns the flag as 1.
- R8: The first read bit is present as soon as the read data phase starts. The output then advances only on falling bus clock edges that follow a rising edge. `bus_data_oe` stays high for exactly 24 bits and drops on the next falling edge. `bus_data_out` is low whenever `bus_data_oe` is low.
- R9: `reg_we` is never high for two cycles in a row and never high while `bus_data_oe` is high.
- R10: After reset, `bus_data_oe`, `bus_data_out` and `reg_we` are low and `reg_addr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_clk | input | 1 | Bus clock from the host, idles high |
| bus_mode | input | 1 | Mode line: low = address phase, high = data phase |
| bus_data_in | input | 1 | Data line as seen from the pad |
| bus_data_out | output | 1 | Read data to the pad driver |
| bus_data_oe | output | 1 | Enable for the open-drain pad driver during reads |
| reg_addr | output | 7 | Register-file address |
| reg_wdata | output | 16 | Register-file write value |
| reg_we | output | 1 | Register-file write strobe, one clock |
| reg_rdata | input | 16 | Register-file read value for `reg_addr` |
| reg_addr_ok | input | 1 | High when `reg_addr` names an existing register |

## Verification
The assertions watch, on every cycle, the properties of the read driver and the write strobe. They check that the strobe is a single-cycle pulse and never overlaps the pad enable. They check that the output stays quiet while undriven and changes only on falling bus edges. They also check that the enable rises only inside a data phase and drops once the mode line falls. Only the directed scenarios can show the bit order and the device identifier match, the handling of each transfer code, the value and address of each write, the content and order of the 24 returned bits, and how the validity flag depends on arming and on `reg_addr_ok`.

// File: rtl/tw_ctl_pkg.sv
package tw_ctl_pkg;

  localparam int BYTE_W = 8;

  // transfer codes in bits 1..0 of the address byte
  localparam logic [1:0] XFER_WRITE = 2'b10;
  localparam logic [1:0] XFER_READ  = 2'b11;

  typedef enum logic [2:0] {
    ST_ADDR,    // address phase, collecting the selector byte
    ST_IGNORE,  // not addressed or transfer finished
    ST_WSEL,    // write/prepare selected, awaiting register byte
    ST_WDATA,   // collecting write value bytes
    ST_RSEL,    // read selected, awaiting data phase
    ST_RD       // driving read bits
  } tw_state_e;

endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int               WIDTH   = 3,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= RST_VAL;
    end else begin
      stage_q[0] <= async_in;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/tw_rx_byte.sv
module tw_rx_byte
  import tw_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              sample_en,
  input  logic              bit_in,
  output logic [BYTE_W-1:0] byte_q,
  output logic              byte_done
);

  localparam int                CW   = $clog2(BYTE_W);
  localparam logic [CW-1:0]     LAST = CW'(BYTE_W - 1);

  logic [CW-1:0]     cnt_q, cnt_d;
  logic [BYTE_W-1:0] sr_q, sr_d;
  logic              done_q, done_d;

  always_comb begin
    cnt_d  = cnt_q;
    sr_d   = sr_q;
    done_d = 1'b0;
    if (clr) begin
      cnt_d = '0;
    end else if (sample_en) begin
      sr_d   = {bit_in, sr_q[BYTE_W-1:1]};   // LSB first: newest bit enters at the top
      done_d = (cnt_q == LAST);
      cnt_d  = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sr_q   <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sr_q   <= sr_d;
      done_q <= done_d;
    end
  end

  assign byte_q    = sr_q;
  assign byte_done = done_q;

endmodule

// File: rtl/tw_tx_shift.sv
module tw_tx_shift #(
  parameter int TW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  input  logic          shift_en,
  input  logic          abort,
  output logic          bit_out,
  output logic          active
);

  localparam int CW = $clog2(TW + 1);

  logic [TW-1:0] sr_q, sr_d;
  logic [CW-1:0] rem_q, rem_d;

  always_comb begin
    sr_d  = sr_q;
    rem_d = rem_q;
    if (abort) begin
      rem_d = '0;
    end else if (load) begin
      sr_d  = load_val;
      rem_d = CW'(TW);
    end else if (shift_en && (rem_q != '0)) begin
      sr_d  = {1'b0, sr_q[TW-1:1]};
      rem_d = rem_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      rem_q <= '0;
    end else begin
      sr_q  <= sr_d;
      rem_q <= rem_d;
    end
  end

  assign active  = (rem_q != '0);
  assign bit_out = sr_q[0] & active;

endmodule

// File: rtl/tw_ctl_slave.sv
module tw_ctl_slave
  import tw_ctl_pkg::*;
#(
  parameter logic [5:0] DEV_ID      = 6'b010100,
  parameter int         AW          = 7,
  parameter int         DW          = 16,
  parameter int         SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_clk,
  input  logic          bus_mode,
  input  logic          bus_data_in,
  output logic          bus_data_out,
  output logic          bus_data_oe,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  output logic          reg_we,
  input  logic [DW-1:0] reg_rdata,
  input  logic          reg_addr_ok
);

  localparam int            NBYTES = DW / BYTE_W;
  localparam int            BCW    = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam int            TXW    = BYTE_W + DW;
  localparam logic [BCW-1:0] BLAST = BCW'(NBYTES - 1);

  // ---------------- reset: async assert, sync release ----------------
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  // ---------------- input synchroniser and edge events ----------------
  logic [2:0] sync_vec;
  logic       s_clk, s_mode, s_data;
  logic       clk_d_q, mode_d_q;
  logic       rise_ev, fall_ev, mode_rise, mode_fall;

  tw_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b001)            // bus clock idles high
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .async_in({bus_data_in, bus_mode, bus_clk}),
    .sync_out(sync_vec)
  );

  assign s_clk  = sync_vec[0];
  assign s_mode = sync_vec[1];
  assign s_data = sync_vec[2];

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      clk_d_q  <= 1'b1;
      mode_d_q <= 1'b0;
    end else begin
      clk_d_q  <= s_clk;
      mode_d_q <= s_mode;
    end
  end

  assign rise_ev   =  s_clk  & ~clk_d_q;
  assign fall_ev   = ~s_clk  &  clk_d_q;
  assign mode_rise =  s_mode & ~mode_d_q;
  assign mode_fall = ~s_mode &  mode_d_q;

  // ---------------- receive path ----------------
  logic [BYTE_W-1:0] rx_byte;
  logic              byte_done;

  tw_rx_byte u_rx (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .clr      (mode_rise | mode_fall),
    .sample_en(rise_ev),
    .bit_in   (s_data),
    .byte_q   (rx_byte),
    .byte_done(byte_done)
  );

  // ---------------- sequencer state ----------------
  tw_state_e     state_q, state_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          armed_q, armed_d;
  logic [DW-1:0] acc_q, acc_d;
  logic [BCW-1:0] bcnt_q, bcnt_d;
  logic          we_q, we_d;
  logic          seen_q, seen_d;
  logic          id_hit;
  logic          tx_active, tx_bit, tx_load, tx_shift;
  logic [TXW-1:0] tx_val;

  assign id_hit = (rx_byte[BYTE_W-1:2] == DEV_ID);

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    armed_d = armed_q;
    acc_d   = acc_q;
    bcnt_d  = bcnt_q;
    we_d    = 1'b0;
    seen_d  = seen_q;
    if (mode_fall) begin
      state_d = ST_ADDR;
    end else if (mode_rise) begin
      seen_d = 1'b0;
      if (state_q == ST_RSEL)      state_d = ST_RD;
      else if (state_q == ST_ADDR) state_d = ST_IGNORE;   // short address phase
    end else begin
      case (state_q)
        ST_ADDR: begin
          if (byte_done) begin
            if (id_hit && rx_byte[1:0] == XFER_WRITE)     state_d = ST_WSEL;
            else if (id_hit && rx_byte[1:0] == XFER_READ) state_d = ST_RSEL;
            else                                          state_d = ST_IGNORE;
          end
        end
        ST_WSEL: begin
          if (byte_done && s_mode) begin
            addr_d = rx_byte[BYTE_W-1:1];
            if (rx_byte[0]) begin
              armed_d = 1'b1;
              state_d = ST_IGNORE;
            end else begin
              armed_d = 1'b0;
              bcnt_d  = '0;
              state_d = ST_WDATA;
            end
          end
        end
        ST_WDATA: begin
          if (byte_done && s_mode) begin
            acc_d = DW'({acc_q, rx_byte});
            if (bcnt_q == BLAST) begin
              we_d    = 1'b1;
              state_d = ST_IGNORE;
            end else begin
              bcnt_d = bcnt_q + 1'b1;
            end
          end
        end
        ST_RD: begin
          if (rise_ev) seen_d = 1'b1;
          if (seen_q && !tx_active) state_d = ST_IGNORE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_ADDR;
      addr_q  <= '0;
      armed_q <= 1'b0;
      acc_q   <= '0;
      bcnt_q  <= '0;
      we_q    <= 1'b0;
      seen_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      armed_q <= armed_d;
      acc_q   <= acc_d;
      bcnt_q  <= bcnt_d;
      we_q    <= we_d;
      seen_q  <= seen_d;
    end
  end

  // ---------------- transmit path ----------------
  // bit 0 of the frame: 0 = valid address
  assign tx_val[BYTE_W-1:0] = {addr_q, ~(armed_q & reg_addr_ok)};

  for (genvar b = 0; b < NBYTES; b++) begin : g_txbyte
    // most significant data byte goes out first
    assign tx_val[BYTE_W*(b+1) +: BYTE_W] = reg_rdata[DW-BYTE_W*(b+1) +: BYTE_W];
  end

  assign tx_load  = mode_rise && (state_q == ST_RSEL);
  assign tx_shift = fall_ev && (state_q == ST_RD) && seen_q;

  tw_tx_shift #(.TW(TXW)) u_tx (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .load    (tx_load),
    .load_val(tx_val),
    .shift_en(tx_shift),
    .abort   (mode_fall),
    .bit_out (tx_bit),
    .active  (tx_active)
  );

  // ---------------- outputs ----------------
  assign bus_data_oe  = (state_q == ST_RD) & tx_active;
  assign bus_data_out = tx_bit & bus_data_oe;
  assign reg_addr     = addr_q;
  assign reg_wdata    = acc_q;
  assign reg_we       = we_q;

endmodule

// File: rtl/tw_ctl_slave_chk.sv
module tw_ctl_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_data_oe,
  input logic bus_data_out,
  input logic reg_we,
  input logic s_mode,
  input logic mode_fall,
  input logic fall_ev
);

  assert_we_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  assert_we_no_oe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && bus_data_oe));

  assert_out_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_data_oe |-> !bus_data_out);

  assert_out_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_data_oe && !fall_ev) |=> (!bus_data_oe || $stable(bus_data_out)));

  assert_oe_in_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_data_oe) |-> s_mode);

  assert_oe_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mode_fall |=> !bus_data_oe);

endmodule

bind tw_ctl_slave tw_ctl_slave_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_data_oe (bus_data_oe),
  .bus_data_out(bus_data_out),
  .reg_we      (reg_we),
  .s_mode      (s_mode),
  .mode_fall   (mode_fall),
  .fall_ev     (fall_ev)
);

// File: tb/tw_ctl_slave_tb.sv
`timescale 1ns/1ps
module tw_ctl_slave_tb;

  localparam int HB = 100;   // bus half period in ns

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_clk, bus_mode, bus_data_in;
  logic        bus_data_out, bus_data_oe;
  logic [6:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic        reg_we, reg_addr_ok;

  int checks = 0;
  int failures = 0;

  // bench register file
  logic [15:0] mem [128];
  int          we_cnt = 0, we_run2 = 0, clash = 0, oe_cycles = 0;
  logic        prev_we = 1'b0;
  logic [6:0]  last_addr;
  logic [15:0] last_data;

  always #5 clk = ~clk;

  tw_ctl_slave u_dut (
    .clk(clk), .rst_n(rst_n), .bus_clk(bus_clk), .bus_mode(bus_mode),
    .bus_data_in(bus_data_in), .bus_data_out(bus_data_out), .bus_data_oe(bus_data_oe),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_rdata(reg_rdata), .reg_addr_ok(reg_addr_ok)
  );

  assign reg_rdata   = mem[reg_addr];
  assign reg_addr_ok = (reg_addr < 7'd96);

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = {8'(i) ^ 8'hA5, 8'(i)};
  end

  always @(posedge clk) begin
    if (reg_we) begin
      we_cnt    <= we_cnt + 1;
      last_addr <= reg_addr;
      last_data <= reg_wdata;
      mem[reg_addr] <= reg_wdata;
    end
    if (reg_we && prev_we) we_run2 <= we_run2 + 1;
    if (reg_we && bus_data_oe) clash <= clash + 1;
    if (bus_data_oe) oe_cycles <= oe_cycles + 1;
    prev_we <= reg_we;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_bit(input logic b);
    bus_clk = 1'b0; bus_data_in = b; #HB;
    bus_clk = 1'b1; #HB;
  endtask

  task automatic bus_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) bus_bit(v[i]);
  endtask

  task automatic addr_phase(input logic [7:0] a);
    bus_mode = 1'b0; #(2*HB);
    bus_byte(a);
  endtask

  task automatic data_start;
    bus_mode = 1'b1; #(2*HB);
  endtask

  task automatic do_write(input logic [7:0] sel, input logic [6:0] a, input logic [15:0] d);
    addr_phase(sel); data_start;
    bus_byte({a, 1'b0}); bus_byte(d[15:8]); bus_byte(d[7:0]);
    #(2*HB);
  endtask

  task automatic do_prepare(input logic [6:0] a);
    addr_phase(8'h52); data_start;
    bus_byte({a, 1'b1});
    #(2*HB);
  endtask

  task automatic do_read(input logic [7:0] sel, output logic [23:0] got,
                         output int oe_hi, output logic oe_after);
    addr_phase(sel); data_start;
    oe_hi = 0;
    for (int i = 0; i < 24; i++) begin
      bus_clk = 1'b0; #HB;
      if (bus_data_oe) oe_hi++;
      got[i] = bus_data_out;
      bus_clk = 1'b1; #HB;
    end
    bus_clk = 1'b0; #HB;
    oe_after = bus_data_oe | bus_data_out;
    bus_clk = 1'b1; #HB;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset;
    check("R10 oe", bus_data_oe, 0);
    check("R10 out", bus_data_out, 0);
    check("R10 we", reg_we, 0);
    check("R10 addr", reg_addr, 0);
  endtask

  task automatic t_write;
    int c0 = we_cnt;
    do_write(8'h52, 7'h05, 16'hA5C3);
    check("R4 write count", we_cnt - c0, 1);
    check("R3 write addr", last_addr, 7'h05);
    check("R1 R4 write data", last_data, 16'hA5C3);
    // extra byte in the same data phase must not write
    c0 = we_cnt;
    bus_byte(8'hFF); #(2*HB);
    check("R4 extra byte", we_cnt - c0, 0);
    check("R4 value kept", mem[5], 16'hA5C3);
  endtask

  task automatic t_prep_read;
    logic [23:0] got; int oe_hi; logic oe_after;
    do_prepare(7'h05);
    do_read(8'h53, got, oe_hi, oe_after);
    check("R6 R7 addr byte", got[7:0], 8'h0A);
    check("R6 msb byte", got[15:8], 8'hA5);
    check("R6 lsb byte", got[23:16], 8'hC3);
    check("R8 oe length", oe_hi, 24);
    check("R8 oe drop", oe_after, 0);
  endtask

  task automatic t_read_unarmed;
    logic [23:0] got; int oe_hi; logic oe_after;
    do_write(8'h52, 7'h10, 16'h1234);
    do_read(8'h53, got, oe_hi, oe_after);
    check("R7 unarmed flag", got[7:0], 8'h21);
    check("R6 unarmed data", {got[15:8], got[23:16]}, 16'h1234);
  endtask

  task automatic t_read_badreg;
    logic [23:0] got; int oe_hi; logic oe_after;
    do_prepare(7'h70);
    do_read(8'h53, got, oe_hi, oe_after);
    check("R7 invalid reg flag", got[7:0], 8'hE1);
    check("R6 invalid reg data", {got[15:8], got[23:16]}, mem[7'h70]);
  endtask

  task automatic t_ignored;
    logic [23:0] got; int oe_hi; logic oe_after;
    int c0 = we_cnt;
    int o0;
    do_write(8'h56, 7'h06, 16'hDEAD);   // identifier mismatch
    do_write(8'h4A, 7'h06, 16'hDEAD);   // bit-reversed identifier
    do_write(8'h51, 7'h06, 16'hBEEF);   // code 01
    do_write(8'h50, 7'h06, 16'hBEEF);   // code 00
    check("R5 R2 no write", we_cnt - c0, 0);
    check("R5 reg untouched", mem[6], {8'h06 ^ 8'hA5, 8'h06});
    o0 = oe_cycles;
    do_read(8'h57, got, oe_hi, oe_after);   // mismatch with read code
    check("R5 no drive", oe_cycles - o0, 0);
    check("R5 line low", got, 0);
  endtask

  task automatic t_strobe;
    check("R9 we single pulse", we_run2, 0);
    check("R9 we with oe", clash, 0);
  endtask

  initial begin
    #3_000_000;
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_clk = 1'b1; bus_mode = 1'b0; bus_data_in = 1'b0;
    #100;
    t_reset;
    rst_n = 1'b1;
    #100;
    t_reset;
    t_write;
    t_prep_read;
    t_read_unarmed;
    t_read_badreg;
    t_ignored;
    t_strobe;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule